// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the interrupt status and enable state for one 8-bit timer/counter. The timer has two compare channels (A and B) and an overflow event. The counter, the compare logic and the waveform generation sit outside the block, which receives only their single-cycle event pulses. Each event sets a sticky flag. Software clears a flag by writing a one to its bit. Hardware clears a flag when the CPU acknowledges the vector that belongs to it.

A flag raises a request only when three things are all one: the global interrupt enable, the matching enable bit in the mask register, and the flag itself. When several requests are qualified, the one with the lowest vector index wins. The request and the winning index leave the block through registers.

The source of the overflow flag depends on the counting mode. In single-direction mode, the wrap from the top value sets it. In up/down mode, the direction reversal at zero sets it.

The register port is a plain write strobe plus an address. Read data follows the address combinationally. The interrupt side is a plain request/acknowledge pair with no back-pressure: the request stays high for as long as any qualified flag remains.

Top module: `tfm_irq_unit`

## Requirements
- R1: After reset, the mask and flag registers read 0x00, `irq_req` is 0 and `irq_vec` is 0.
- R2: The mask register is at address 0 and the flag register is at address 1. In both registers, bit 0 is overflow, bit 1 is compare A and bit 2 is compare B. Bits 7..3 always read zero, and writes to them have no effect. Any other address reads 0x00.
- R3: A write to address 0 stores bits 2..0 as the three enable bits, and a read returns them.
- R4: A pulse on `ev_cmpa` sets the compare A flag, and a pulse on `ev_cmpb` sets the compare B flag. With `mode_updown`=0, a pulse on `ev_wrap` sets the overflow flag and `ev_bottom` has no effect.
- R5: A write to address 1 clears each flag whose data bit is one and leaves each flag whose data bit is zero unchanged.
- R6: When `irq_ack` is 1, the flag whose vector index equals `ack_idx` is cleared (0 = compare A, 1 = compare B, 2 = overflow). An `ack_idx` of 3 clears nothing.
- R7: One cycle after the flags, mask or `global_ie` change, `irq_req` equals `global_ie` AND (at least one flag is set together with its enable bit).
- R8: With `mode_updown`=1, a pulse on `ev_bottom` sets the overflow flag and `ev_wrap` has no effect.
- R9: `irq_vec` is registered alongside `irq_req`. It gives the lowest qualified vector index, in the order compare A (0), compare B (1), overflow (2), and it is 0 when no request is present.
- R10: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R11: An acknowledge leaves every other flag untouched. `irq_req` stays asserted, with the next index, while any qualified flag remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_cmpa | input | 1 | Compare A match pulse |
| ev_cmpb | input | 1 | Compare B match pulse |
| ev_wrap | input | 1 | Counter wrap from top value pulse |
| ev_bottom | input | 1 | Direction reversal at zero pulse |
| mode_updown | input | 1 | 1 = up/down counting mode |
| global_ie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 = mask, 1 = flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 2 | Registered winning vector index |
| irq_ack | input | 1 | Vector taken |
| ack_idx | input | 2 | Index of the vector taken |

## Verification
The bench targets these corner cases:
- **Set event and clear in the same cycle.** If the clear won, the event would be lost and the flag would read zero.
- **Overflow source in each counting mode.** A design that swapped the two sources, or accepted both, would show the wrong flag value after an ignored pulse.
- **Acknowledge while several flags are pending.** A design that cleared every flag would drop `irq_req` instead of moving on to the next index.
- **Writes of zeros and writes to the upper bits.** A flag that cleared on a zero, or a nonzero value in bits 7..3, shows up directly in the read data.

A random stream of events, register writes, acknowledges and enable changes runs against a cycle model. Because of it, a register stage missing from, or added to, the request path would miscompare on the first change.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  localparam int NSRC     = 3;
  localparam int VEC_W    = 2;
  localparam int IDX_CMPA = 0;
  localparam int IDX_CMPB = 1;
  localparam int IDX_OVF  = 2;

  // register bit position of each vector index
  function automatic int reg_pos(input int idx);
    case (idx)
      IDX_CMPA: return 1;
      IDX_CMPB: return 2;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/tfm_event_map.sv
module tfm_event_map
  import tfm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_cmpa,
  input  logic            ev_cmpb,
  input  logic            ev_wrap,
  input  logic            ev_bottom,
  input  logic            mode_updown,
  output logic [NSRC-1:0] set_vec
);
  always_comb begin
    set_vec           = '0;
    set_vec[IDX_CMPA] = ev_cmpa;
    set_vec[IDX_CMPB] = ev_cmpb;
    set_vec[IDX_OVF]  = mode_updown ? ev_bottom : ev_wrap;
  end

  AST_UPDOWN_WRAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_updown && ev_wrap && !ev_bottom) |-> !set_vec[IDX_OVF]); // R8
  AST_SINGLE_BOTTOM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_updown && ev_bottom && !ev_wrap) |-> !set_vec[IDX_OVF]); // R4
endmodule

// File: rtl/tfm_flag_bank.sv
module tfm_flag_bank
  import tfm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set_vec,
  input  logic             mask_we,
  input  logic             flag_we,
  input  logic [NSRC-1:0]  wr_bits,
  input  logic             ack_valid,
  input  logic [VEC_W-1:0] ack_idx,
  output logic [NSRC-1:0]  mask_q,
  output logic [NSRC-1:0]  flag_q
);
  logic [NSRC-1:0] clr_vec;

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    assign clr_vec[i] = (flag_we && wr_bits[i]) ||
                        (ack_valid && (ack_idx == VEC_W'(i)));

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q[i]); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]); // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && !set_vec[i]) |=> (flag_q[i] == $past(flag_q[i]))); // R5
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      if (mask_we) mask_q <= wr_bits;
      flag_q <= set_vec | (flag_q & ~clr_vec);
    end
  end

  AST_MASK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wr_bits))); // R3
endmodule

// File: rtl/tfm_arbiter.sv
module tfm_arbiter
  import tfm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             global_ie,
  input  logic [NSRC-1:0]  mask_q,
  input  logic [NSRC-1:0]  flag_q,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  logic [NSRC-1:0]  qual;
  logic             win;
  logic [VEC_W-1:0] win_idx;

  assign qual = flag_q & mask_q & {NSRC{global_ie}};

  always_comb begin
    win     = 1'b0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (qual[i]) begin
        win     = 1'b1;
        win_idx = VEC_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= win;
      irq_vec <= win_idx;
    end
  end

  AST_REQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (global_ie && |(flag_q & mask_q)) |=> irq_req); // R7
  AST_REQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !(global_ie && |(flag_q & mask_q)) |=> !irq_req); // R7
  AST_CMPA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (global_ie && flag_q[IDX_CMPA] && mask_q[IDX_CMPA]) |=> (irq_vec == VEC_W'(IDX_CMPA))); // R9
endmodule

// File: rtl/tfm_irq_unit.sv
module tfm_irq_unit
  import tfm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 1,
  parameter int MASK_ADDR = 0,
  parameter int FLAG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cmpa,
  input  logic              ev_cmpb,
  input  logic              ev_wrap,
  input  logic              ev_bottom,
  input  logic              mode_updown,
  input  logic              global_ie,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic [VEC_W-1:0]  ack_idx
);
  logic [NSRC-1:0]   set_vec, wr_bits, mask_q, flag_q;
  logic [DATA_W-1:0] mask_img, flag_img;
  logic              sel_mask, sel_flag;
  logic              unused_hi;

  assign sel_mask  = (reg_addr == ADDR_W'(MASK_ADDR));
  assign sel_flag  = (reg_addr == ADDR_W'(FLAG_ADDR));
  assign unused_hi = ^reg_wdata[DATA_W-1:NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_map
    localparam int P = reg_pos(i);
    assign wr_bits[i] = reg_wdata[P];
  end

  always_comb begin
    mask_img = '0;
    flag_img = '0;
    for (int i = 0; i < NSRC; i++) begin
      mask_img[reg_pos(i)] = mask_q[i];
      flag_img[reg_pos(i)] = flag_q[i];
    end
  end

  assign reg_rdata = sel_mask ? mask_img : (sel_flag ? flag_img : '0);

  tfm_event_map u_map (
    .clk(clk), .rst_n(rst_n), .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb),
    .ev_wrap(ev_wrap), .ev_bottom(ev_bottom), .mode_updown(mode_updown),
    .set_vec(set_vec)
  );

  tfm_flag_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .mask_we(reg_wr && sel_mask), .flag_we(reg_wr && sel_flag),
    .wr_bits(wr_bits), .ack_valid(irq_ack), .ack_idx(ack_idx),
    .mask_q(mask_q), .flag_q(flag_q)
  );

  tfm_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .global_ie(global_ie), .mask_q(mask_q),
    .flag_q(flag_q), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NSRC] == '0); // R2
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == '0)); // R9
endmodule

// File: tb/tfm_irq_unit_test.sv
`timescale 1ns/1ps
module tfm_irq_unit_test;
  logic clk = 0, rst_n = 0;
  logic ev_cmpa = 0, ev_cmpb = 0, ev_wrap = 0, ev_bottom = 0, mode_updown = 0, global_ie = 0;
  logic reg_wr = 0, irq_ack = 0;
  logic [0:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_req;
  logic [1:0] irq_vec, ack_idx = 0;

  int total = 0, bad = 0;
  bit finished = 0;
  // model, vector order: 0 = cmp A, 1 = cmp B, 2 = overflow
  bit m_mask[3];
  bit m_flag[3];

  always #2 clk = ~clk;

  tfm_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb), .ev_wrap(ev_wrap),
    .ev_bottom(ev_bottom), .mode_updown(mode_updown), .global_ie(global_ie),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .ack_idx(ack_idx)
  );

  function automatic int bitpos(input int idx);
    return (idx == 0) ? 1 : (idx == 1) ? 2 : 0;
  endfunction

  function automatic logic [7:0] image(input bit useflag);
    logic [7:0] v = 8'h00;
    for (int i = 0; i < 3; i++) v[bitpos(i)] = useflag ? m_flag[i] : m_mask[i];
    return v;
  endfunction

  function automatic int exp_vec();
    for (int i = 0; i < 3; i++) if (global_ie && m_mask[i] && m_flag[i]) return i;
    return 0;
  endfunction

  function automatic bit exp_req();
    bit r = 0;
    for (int i = 0; i < 3; i++) r |= global_ie && m_mask[i] && m_flag[i];
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input bit a, b, w, bt, ud, gie, wr, input bit [0:0] ad,
                       input logic [7:0] wd, input bit ak, input logic [1:0] ai);
    ev_cmpa = a; ev_cmpb = b; ev_wrap = w; ev_bottom = bt; mode_updown = ud;
    global_ie = gie; reg_wr = wr; reg_addr = ad; reg_wdata = wd; irq_ack = ak; ack_idx = ai;
  endtask

  // one clock: predict, advance, update model, compare
  task automatic tick();
    bit r = exp_req();
    int v = exp_vec();
    bit set[3];
    bit clr;
    set[0] = ev_cmpa; set[1] = ev_cmpb; set[2] = mode_updown ? ev_bottom : ev_wrap;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) begin
      clr = (reg_wr && reg_addr == 1 && reg_wdata[bitpos(i)]) || (irq_ack && ack_idx == 2'(i));
      m_flag[i] = set[i] | (m_flag[i] & ~clr);
      if (reg_wr && reg_addr == 0) m_mask[i] = reg_wdata[bitpos(i)];
    end
    chk("R7 irq_req", irq_req, r);
    chk("R9 irq_vec", irq_vec, v);
    chk(reg_addr == 1 ? "R4 flag read" : "R3 mask read", reg_rdata, image(reg_addr == 1));
  endtask

  task automatic idle(input bit gie, input bit [0:0] ad);
    drive(0,0,0,0,0,gie,0,ad,8'h00,0,2'd0);
  endtask

  initial begin
    #(4 * 150000);
    chk("watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 irq_req", irq_req, 0);
    chk("R1 irq_vec", irq_vec, 0);
    reg_addr = 0; #1 chk("R1 mask", reg_rdata, 0);
    reg_addr = 1; #1 chk("R1 flags", reg_rdata, 0);

    // R2/R3: upper bits ignored
    drive(0,0,0,0,0,0,1,0,8'hFF,0,0); tick();
    idle(0,0); tick(); chk("R2 mask upper zero", reg_rdata, 8'h07);
    // R4: normal mode wrap sets overflow, bottom ignored
    drive(0,0,0,1,0,0,0,1,0,0,0); tick(); chk("R4 bottom ignored", reg_rdata, 8'h00);
    drive(0,0,1,0,0,0,0,1,0,0,0); tick(); chk("R4 wrap sets ovf", reg_rdata, 8'h01);
    drive(1,0,0,0,0,0,0,1,0,0,0); tick(); chk("R4 cmpA flag", reg_rdata, 8'h03);
    // R5: write zero keeps, write one clears
    drive(0,0,0,0,0,0,1,1,8'h00,0,0); tick(); chk("R5 write zero keeps", reg_rdata, 8'h03);
    drive(0,0,0,0,0,0,1,1,8'hFD,0,0); tick(); chk("R5 write one clears", reg_rdata, 8'h02);
    drive(0,0,0,0,0,0,1,1,8'h02,0,0); tick();
    // R8: up/down mode
    drive(0,0,1,0,1,0,0,1,0,0,0); tick(); chk("R8 wrap ignored", reg_rdata, 8'h00);
    drive(0,0,0,1,1,0,0,1,0,0,0); tick(); chk("R8 bottom sets ovf", reg_rdata, 8'h01);
    // R10: set beats write-one and ack
    drive(0,0,0,1,1,0,1,1,8'h01,0,0); tick(); chk("R10 set beats w1c", reg_rdata, 8'h01);
    drive(0,1,0,0,0,0,0,1,0,1,2'd1); tick(); chk("R10 set beats ack", reg_rdata, 8'h05);
    // R6/R11/R9: all pending, ack walks down the order
    drive(1,0,0,0,0,1,0,1,0,0,0); tick();
    idle(1,1); tick(); chk("R9 cmpA wins", irq_vec, 0);
    drive(0,0,0,0,0,1,0,1,0,1,2'd0); tick(); chk("R6 ack clears A only", reg_rdata, 8'h05);
    idle(1,1); tick(); chk("R11 req stays", irq_req, 1); chk("R11 next vec", irq_vec, 1);
    drive(0,0,0,0,0,1,0,1,0,1,2'd3); tick(); chk("R6 idx 3 clears nothing", reg_rdata, 8'h05);
    // R7: global enable gates
    idle(0,1); tick(); idle(0,1); tick(); chk("R7 global off", irq_req, 0);
    drive(0,0,0,0,0,1,1,0,8'h01,0,0); tick(); idle(1,1); tick();
    chk("R7 mask only ovf", irq_vec, 2);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      drive($urandom_range(0,7) == 0, $urandom_range(0,7) == 0, $urandom_range(0,5) == 0,
            $urandom_range(0,5) == 0, $urandom_range(0,1), $urandom_range(0,9) != 0,
            $urandom_range(0,5) == 0, 1'($urandom_range(0,1)), 8'($urandom),
            $urandom_range(0,3) == 0, 2'($urandom_range(0,3)));
      tick();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule